// File: doc/BRIEF.md
# Sleep Mode and Wake Controller

This block decides which clock domains of a small microcontroller keep running while the core sleeps, and when the core may run again. A sleep strobe captures a 3-bit mode select and the crystal-option flag into an effective sleep mode. The effective mode sets the clock enables for the CPU domain, the I/O domain, the asynchronous timer domain and the main oscillator. While the block sleeps it watches the wake sources. Which sources count depends on the mode.

When a wake source qualifies, a down-counter runs for the mode's wake latency. The latency is a full oscillator startup delay for the deepest modes, a fixed six cycles when the oscillator was kept running, and one cycle for idle. After that the CPU clock comes back and a one-cycle ready pulse is raised. A per-peripheral power-reduction mask further gates the I/O clock to each peripheral. Level-sensitive wake lines must hold for a minimum number of consecutive samples before they count.

Top module: `slumber_ctrl`

## Requirements
- R1: After reset the controller runs: `cpu_clk_en`, `io_clk_en`, `async_clk_en` and `osc_run` are 1 and `wake_ready` is 0.
- R2: A sleep strobe with `mode_sel` = 3'b010 (deep power-down) sets all four domain enables to 0 from the next cycle.
- R3: With `mode_sel` = 3'b011 (timer-keeping power-down), only `async_clk_en` stays 1 while asleep.
- R4: With `xtal_opt` = 1, code 3'b110 (oscillator-held power-down) keeps only `osc_run` at 1, and code 3'b111 (oscillator-held timer-keeping) keeps `osc_run` and `async_clk_en` at 1.
- R5: Every other code, and codes 3'b110/3'b111 with `xtal_opt` = 0, give idle: `cpu_clk_en` is 0 and the other three enables are 1.
- R6: In every sleep mode, any of `ext_rst`, `wdt_rst`, `bod_rst`, `addr_match`, `pin_chg`, any bit of `edge_irq`, or a qualified `lvl_irq` bit starts a wake.
- R7: Timer overflow/compare events (`tmr_ovf` and `tmr_ovf_ie`, or `tmr_cmp` and `tmr_cmp_ie`, each also needing `glob_ie`) start a wake only in the timer-keeping modes (3'b011, oxc 3'b111 with crystal) and in idle. In the other modes, and without the enables, they have no effect.
- R8: From the two plain power-down modes, `wake_ready` rises `STARTUP_CYC` clock edges after the edge that sampled the wake source.
- R9: From the two oscillator-held modes the wake latency is exactly 6 edges. From idle it is 1 edge.
- R10: A `lvl_irq` bit counts as a wake source only after it has been sampled high on `LVL_HOLD` consecutive edges. A shorter pulse wakes nothing.
- R11: `wake_ready` is a one-cycle pulse, raised in the first cycle in which `cpu_clk_en` is 1 again.
- R12: `periph_clk_en[i]` equals `io_clk_en` with bit `i` of `pwr_red` cleared, so a set mask bit stops peripheral `i`, in run and in every sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low reset of the controller |
| mode_sel | input | 3 | Sleep-mode select, sampled on the sleep strobe |
| sleep_req | input | 1 | Sleep strobe, honoured only while running |
| xtal_opt | input | 1 | External crystal/resonator clock option chosen |
| ext_rst | input | 1 | External reset request (wake source) |
| wdt_rst | input | 1 | Watchdog reset request (wake source) |
| bod_rst | input | 1 | Brown-out reset request (wake source) |
| addr_match | input | 1 | Two-wire serial address match (wake source) |
| lvl_irq | input | LVL_W | Level-sensitive external interrupt lines |
| edge_irq | input | EDGE_W | Detected events of the edge/any-change interrupt group |
| pin_chg | input | 1 | Pin-change interrupt |
| tmr_ovf | input | 1 | Timer overflow event |
| tmr_cmp | input | 1 | Timer compare event |
| tmr_ovf_ie | input | 1 | Timer overflow interrupt enable |
| tmr_cmp_ie | input | 1 | Timer compare interrupt enable |
| glob_ie | input | 1 | Global interrupt enable |
| pwr_red | input | N_PERIPH | Per-peripheral clock stop mask |
| cpu_clk_en | output | 1 | CPU clock domain enable |
| io_clk_en | output | 1 | I/O clock domain enable |
| async_clk_en | output | 1 | Asynchronous timer domain enable |
| osc_run | output | 1 | Main oscillator run request |
| periph_clk_en | output | N_PERIPH | Per-peripheral clock enables |
| wake_ready | output | 1 | One-cycle pulse when the CPU clock resumes |

## Verification
The bench builds the block with `STARTUP_CYC` = 20, `LVL_HOLD` = 4, eight peripherals and four lines in each interrupt group. A 20-cycle startup delay makes the long oscillator-restart path observable next to the 6-cycle and 1-cycle paths, and the three latencies stay clearly apart. A hold count of 4 allows a level pulse one sample short of qualifying to be shown to wake nothing, followed by a held level that does wake.

// File: rtl/slumber_pkg.sv
package slumber_pkg;

  typedef enum logic [2:0] {
    M_IDLE  = 3'd0,
    M_PDOWN = 3'd1,
    M_PSAVE = 3'd2,
    M_STBY  = 3'd3,
    M_XSTBY = 3'd4
  } slp_mode_e;

  typedef enum logic [1:0] {
    S_RUN   = 2'd0,
    S_SLEEP = 2'd1,
    S_WAIT  = 2'd2
  } slp_state_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic tmr;
    logic osc;
  } clk_dom_t;

  localparam int unsigned STBY_WAKE_CYC = 6;
  localparam int unsigned IDLE_WAKE_CYC = 1;

  // Turn the raw select code plus the crystal flag into an effective mode
  function automatic slp_mode_e decode_mode(input logic [2:0] sel, input logic xtal);
    slp_mode_e m;
    case (sel)
      3'b010:  m = M_PDOWN;
      3'b011:  m = M_PSAVE;
      3'b110:  m = xtal ? M_STBY  : M_IDLE;
      3'b111:  m = xtal ? M_XSTBY : M_IDLE;
      default: m = M_IDLE;
    endcase
    return m;
  endfunction

  // Domains kept alive while asleep in a given mode
  function automatic clk_dom_t sleep_domains(input slp_mode_e m);
    clk_dom_t d;
    d = '0;
    case (m)
      M_IDLE:  begin d.io = 1'b1; d.tmr = 1'b1; d.osc = 1'b1; end
      M_PSAVE: d.tmr = 1'b1;
      M_STBY:  d.osc = 1'b1;
      M_XSTBY: begin d.tmr = 1'b1; d.osc = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction

  // Timer events may wake only where the timer domain keeps running
  function automatic logic timer_wake_ok(input slp_mode_e m);
    return (m == M_PSAVE) || (m == M_XSTBY) || (m == M_IDLE);
  endfunction

  // Wake latency in clock edges for each mode
  function automatic int unsigned wake_delay(input slp_mode_e m, input int unsigned startup);
    int unsigned d;
    case (m)
      M_PDOWN, M_PSAVE: d = startup;
      M_STBY, M_XSTBY:  d = STBY_WAKE_CYC;
      default:          d = IDLE_WAKE_CYC;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/slumber_lvl_filter.sv
module slumber_lvl_filter #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  output logic qualified
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_len <= '0;
    else if (!lvl_in)          run_len <= '0;
    else if (run_len < HOLD_V) run_len <= run_len + 1'b1;
  end

  assign qualified = (run_len == HOLD_V);

  // R10
  lvl_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qualified |-> lvl_in || $past(lvl_in));

endmodule

// File: rtl/slumber_delay_ctr.sv
module slumber_delay_ctr #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= load_val;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign done = (remain == {{(CW-1){1'b0}}, 1'b1});

  // R8
  delay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $past(remain) != '0) |-> remain == $past(remain) - 1'b1);

endmodule

// File: rtl/slumber_clk_gate.sv
module slumber_clk_gate
  import slumber_pkg::*;
#(
  parameter int unsigned N_PERIPH = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  slp_state_e          st,
  input  slp_mode_e           mode,
  input  logic [N_PERIPH-1:0] mask,
  output clk_dom_t            dom,
  output logic [N_PERIPH-1:0] periph_en
);
  always_comb begin
    case (st)
      S_SLEEP: dom = sleep_domains(mode);
      S_WAIT: begin
        dom     = sleep_domains(mode);
        dom.osc = 1'b1;
      end
      default: dom = '1;
    endcase
  end

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_pgate
    assign periph_en[p] = dom.io & ~mask[p];
  end

  // R2
  pdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && mode == M_PDOWN) |-> (dom == '0));

  // R12
  periph_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dom.io |-> (periph_en == '0));

endmodule

// File: rtl/slumber_ctrl.sv
module slumber_ctrl
  import slumber_pkg::*;
#(
  parameter int unsigned STARTUP_CYC = 16384,
  parameter int unsigned LVL_HOLD    = 4,
  parameter int unsigned LVL_W       = 4,
  parameter int unsigned EDGE_W      = 4,
  parameter int unsigned N_PERIPH    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          mode_sel,
  input  logic                sleep_req,
  input  logic                xtal_opt,
  input  logic                ext_rst,
  input  logic                wdt_rst,
  input  logic                bod_rst,
  input  logic                addr_match,
  input  logic [LVL_W-1:0]    lvl_irq,
  input  logic [EDGE_W-1:0]   edge_irq,
  input  logic                pin_chg,
  input  logic                tmr_ovf,
  input  logic                tmr_cmp,
  input  logic                tmr_ovf_ie,
  input  logic                tmr_cmp_ie,
  input  logic                glob_ie,
  input  logic [N_PERIPH-1:0] pwr_red,
  output logic                cpu_clk_en,
  output logic                io_clk_en,
  output logic                async_clk_en,
  output logic                osc_run,
  output logic [N_PERIPH-1:0] periph_clk_en,
  output logic                wake_ready
);
  localparam int unsigned MAX_DLY = (STARTUP_CYC > STBY_WAKE_CYC) ? STARTUP_CYC : STBY_WAKE_CYC;
  localparam int unsigned DCW     = $clog2(MAX_DLY + 1);

  slp_state_e st;
  slp_mode_e  mode;
  clk_dom_t   dom;

  // Named internal events
  logic [LVL_W-1:0] lvl_q;
  logic             base_hit;
  logic             tmr_hit;
  logic             tmr_allowed;
  logic             wake_hit;
  logic             dly_load;
  logic [DCW-1:0]   dly_val;
  logic             dly_done;

  for (genvar i = 0; i < LVL_W; i++) begin : g_lvl
    slumber_lvl_filter #(.HOLD(LVL_HOLD)) i_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .lvl_in    (lvl_irq[i]),
      .qualified (lvl_q[i])
    );
  end

  assign base_hit    = ext_rst | wdt_rst | bod_rst | addr_match | pin_chg
                     | (|lvl_q) | (|edge_irq);
  assign tmr_hit     = glob_ie & ((tmr_ovf & tmr_ovf_ie) | (tmr_cmp & tmr_cmp_ie));
  assign tmr_allowed = timer_wake_ok(mode);
  assign wake_hit    = base_hit | (tmr_allowed & tmr_hit);
  assign dly_load    = (st == S_SLEEP) && wake_hit;
  assign dly_val     = DCW'(wake_delay(mode, STARTUP_CYC));

  slumber_delay_ctr #(.CW(DCW)) i_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .done     (dly_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      mode       <= M_IDLE;
      wake_ready <= 1'b0;
    end else begin
      wake_ready <= (st == S_WAIT) && dly_done;
      case (st)
        S_RUN: if (sleep_req) begin
          st   <= S_SLEEP;
          mode <= decode_mode(mode_sel, xtal_opt);
        end
        S_SLEEP: if (wake_hit) st <= S_WAIT;
        S_WAIT:  if (dly_done) st <= S_RUN;
        default: st <= S_RUN;
      endcase
    end
  end

  slumber_clk_gate #(.N_PERIPH(N_PERIPH)) i_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .mode      (mode),
    .mask      (pwr_red),
    .dom       (dom),
    .periph_en (periph_clk_en)
  );

  assign cpu_clk_en   = dom.cpu;
  assign io_clk_en    = dom.io;
  assign async_clk_en = dom.tmr;
  assign osc_run      = dom.osc;

  // R11
  cpu_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> wake_ready);

  // R11
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ready |=> !wake_ready);

  // R7
  tmr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SLEEP && !base_hit && !tmr_allowed) |=> (st == S_SLEEP));

  // R8
  wait_keeps_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (osc_run && !cpu_clk_en));

endmodule

// File: tb/test_slumber_ctrl.sv
module test_slumber_ctrl;
  localparam int unsigned STARTUP = 20;
  localparam int unsigned HOLD    = 4;
  localparam int unsigned NP      = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode_sel = '0;
  logic sleep_req = 0, xtal_opt = 0;
  logic ext_rst = 0, wdt_rst = 0, bod_rst = 0, addr_match = 0, pin_chg = 0;
  logic [3:0] lvl_irq = '0, edge_irq = '0;
  logic tmr_ovf = 0, tmr_cmp = 0, tmr_ovf_ie = 0, tmr_cmp_ie = 0, glob_ie = 0;
  logic [NP-1:0] pwr_red = '0;
  logic cpu_clk_en, io_clk_en, async_clk_en, osc_run, wake_ready;
  logic [NP-1:0] periph_clk_en;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  bit armed = 0;
  int elapsed = 0;

  always #2.5 clk = ~clk;

  slumber_ctrl #(
    .STARTUP_CYC(STARTUP), .LVL_HOLD(HOLD), .LVL_W(4), .EDGE_W(4), .N_PERIPH(NP)
  ) i_slumber_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sleep_req(sleep_req),
    .xtal_opt(xtal_opt), .ext_rst(ext_rst), .wdt_rst(wdt_rst), .bod_rst(bod_rst),
    .addr_match(addr_match), .lvl_irq(lvl_irq), .edge_irq(edge_irq),
    .pin_chg(pin_chg), .tmr_ovf(tmr_ovf), .tmr_cmp(tmr_cmp),
    .tmr_ovf_ie(tmr_ovf_ie), .tmr_cmp_ie(tmr_cmp_ie), .glob_ie(glob_ie),
    .pwr_red(pwr_red), .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en),
    .async_clk_en(async_clk_en), .osc_run(osc_run),
    .periph_clk_en(periph_clk_en), .wake_ready(wake_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Domain word: {cpu, io, async, osc}
  task automatic chk_dom(input string req, input logic [3:0] exp);
    chk(req, {cpu_clk_en, io_clk_en, async_clk_en, osc_run}, exp);
  endtask

  // Driver side of the scoreboard: expected wake latency in edges
  task automatic arm(input int lat, input string tag);
    exp_q.push_back(lat);
    tag_q.push_back(tag);
    elapsed = 0;
    armed = 1;
  endtask

  // Monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (armed) elapsed++;
    if (rst_n && wake_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R7: unexpected wake_ready, actual 1 expected 0");
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (elapsed != e) begin
          errors++;
          $display("FAIL %s: wake latency actual %0d expected %0d", t, elapsed, e);
        end
      end
      armed = 0;
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (exp_q.size() != 0 && n < 100) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s: no wake, actual pending %0d expected 0", req, exp_q.size());
      exp_q.delete();
      tag_q.delete();
      armed = 0;
    end
    @(negedge clk);
  endtask

  task automatic go_sleep(input logic [2:0] sel, input logic xt);
    @(negedge clk);
    mode_sel = sel;
    xtal_opt = xt;
    sleep_req = 1;
    @(negedge clk);
    sleep_req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_dom("R1 reset domains", 4'b1111);
    chk("R1 reset ready", wake_ready, 0);

    // R12 mask in run
    pwr_red = 8'hA5;
    @(negedge clk);
    chk("R12 run periph", periph_clk_en, 8'h5A);

    // R2 deep power-down, R12 mask while io off, R8 long latency via pin change
    go_sleep(3'b010, 1'b0);
    chk_dom("R2 pdown domains", 4'b0000);
    chk("R12 pdown periph", periph_clk_en, 8'h00);
    // R7 timer event with all enables ignored in power-down
    tmr_ovf_ie = 1; glob_ie = 1; tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    repeat (30) @(negedge clk);
    chk("R7 timer ignored in pdown", cpu_clk_en, 0);
    pin_chg = 1; arm(STARTUP + 1, "R8 pdown pin_chg");
    @(negedge clk); pin_chg = 0;
    wait_done("R6 pin_chg");
    chk_dom("R11 back to run", 4'b1111);

    // R3 timer-keeping mode; timer without global enable ignored
    go_sleep(3'b011, 1'b0);
    chk_dom("R3 psave domains", 4'b0010);
    glob_ie = 0; tmr_ovf = 1;
    @(negedge clk); tmr_ovf = 0;
    repeat (30) @(negedge clk);
    chk("R7 no global enable", cpu_clk_en, 0);
    glob_ie = 1; tmr_ovf = 1; arm(STARTUP + 1, "R7 psave timer wake");
    @(negedge clk); tmr_ovf = 0;
    wait_done("R7 psave timer");

    // R4 oscillator-held, wake by address match
    go_sleep(3'b110, 1'b1);
    chk_dom("R4 standby domains", 4'b0001);
    addr_match = 1; arm(6 + 1, "R9 standby latency");
    @(negedge clk); addr_match = 0;
    wait_done("R6 addr_match");

    // R4 oscillator-held timer-keeping, wake by compare
    go_sleep(3'b111, 1'b1);
    chk_dom("R4 ext standby domains", 4'b0011);
    tmr_cmp_ie = 1; tmr_cmp = 1; arm(6 + 1, "R9 ext standby timer");
    @(negedge clk); tmr_cmp = 0;
    wait_done("R7 compare");

    // R5 standby code without crystal falls back to idle
    go_sleep(3'b110, 1'b0);
    chk_dom("R5 no-crystal idle", 4'b0111);
    chk("R12 idle periph", periph_clk_en, 8'h5A);
    edge_irq = 4'b0100; arm(1 + 1, "R9 idle latency");
    @(negedge clk); edge_irq = '0;
    wait_done("R6 edge_irq");

    // R5 unlisted code
    go_sleep(3'b000, 1'b1);
    chk_dom("R5 code 000 idle", 4'b0111);
    wdt_rst = 1; arm(2, "R9 idle wdt");
    @(negedge clk); wdt_rst = 0;
    wait_done("R6 wdt_rst");

    // R10 level hold in power-down
    go_sleep(3'b010, 1'b0);
    lvl_irq[2] = 1;
    repeat (HOLD - 1) @(negedge clk);
    lvl_irq[2] = 0;
    repeat (10) @(negedge clk);
    chk("R10 short level ignored", cpu_clk_en, 0);
    lvl_irq[2] = 1; arm(HOLD + STARTUP + 1, "R10 held level");
    wait_done("R10 level wake");
    lvl_irq[2] = 0;

    // R6 external reset and brown-out from power-down
    go_sleep(3'b010, 1'b0);
    ext_rst = 1; arm(STARTUP + 1, "R6 ext_rst");
    @(negedge clk); ext_rst = 0;
    wait_done("R6 ext_rst");
    go_sleep(3'b011, 1'b0);
    bod_rst = 1; arm(STARTUP + 1, "R6 bod_rst");
    @(negedge clk); bod_rst = 0;
    wait_done("R6 bod_rst");

    pwr_red = 8'h0F;
    @(negedge clk);
    chk("R12 mask change", periph_clk_en, 8'hF0);
    chk("R11 ready low", wake_ready, 0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule